// File: doc/BRIEF.md
# Search Key Match Sequencer

This block lets a host run one lookup against a synchronous associative-memory match port as a single, indivisible transaction. When the host raises a request, the sequencer registers the 32-bit key, drives it onto the device data lanes and pulses an active-low latch/start strobe for one cycle. It then holds the write phase open for as long as the device's search-running line is high. Next it runs a three-cycle read phase with the device read enable asserted, and registers the returned word.

The returned word goes back to the host with its top bit replaced by the device's no-match line. That bit is clear when the lookup hit and the data is valid, and set when nothing matched. A separate hit flag carries the same information in positive sense. The host is held off with a busy signal from acceptance until the result is registered. If the search-running line stays high for a parameterized number of consecutive stall cycles, the lookup is abandoned and the response is flagged as a timeout.

Top module: `key_match_seq`

## Requirements
- R1: After reset, busy, rsp_valid, rsp_timeout and dev_key_drv are 0, and dev_start_n and dev_rd_n are 1.
- R2: A request seen with busy low is accepted at that clock edge. In the next cycle the key is driven on dev_key with dev_key_drv high and dev_start_n low, and dev_start_n is low for exactly one cycle per lookup.
- R3: The write phase lasts two cycles. dev_key and dev_key_drv are held through its second cycle, and that cycle repeats while dev_searching is high. With the device model used, a search-running pulse of H cycles (H>=1) adds H-1 stall cycles.
- R4: The read phase keeps dev_rd_n low for exactly three cycles when dev_searching is low, with dev_key_drv low throughout. dev_start_n and dev_rd_n are never low together.
- R5: rsp_valid pulses for one cycle, in the cycle after the last read cycle. rsp_word[30:0] equals dev_rdata[30:0] from that last read cycle. rsp_word[31] equals dev_nomatch (1 = no match, 0 = accepted), and rsp_hit is its inverse.
- R6: busy is high from the cycle after acceptance up to, but not including, the rsp_valid cycle, so an uncontended lookup keeps busy high for 5 cycles. Requests made while busy is high are ignored and start no strobe.
- R7: If dev_searching stays high for TIMEOUT_CYC consecutive stall cycles, the lookup ends with rsp_valid, rsp_timeout = 1, rsp_hit = 0 and rsp_word = 0. No read cycle occurs, and busy stays high for TIMEOUT_CYC + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the match port |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host lookup request |
| req_key | input | 32 | Search key |
| busy | output | 1 | Lookup in progress; requests are ignored |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_word | output | 32 | Result; bit 31 set means no match |
| rsp_hit | output | 1 | 1 when the lookup matched |
| rsp_timeout | output | 1 | Lookup abandoned on search timeout |
| dev_key | output | 32 | Key driven to the device data lanes |
| dev_key_drv | output | 1 | Drive enable for dev_key |
| dev_start_n | output | 1 | Active-low latch/start-search strobe |
| dev_rd_n | output | 1 | Active-low device read enable |
| dev_searching | input | 1 | High while the device search runs |
| dev_nomatch | input | 1 | Device no-match line (high = miss) |
| dev_rdata | input | 31 | Device result data, lower lanes |

## Verification
The assertions assume the device behaves like a real match port. dev_searching may only rise because of a strobe, and dev_rdata and dev_nomatch are meaningful only while dev_rd_n is low. The host may raise req_valid at any time, including while busy. The bench's device model follows these rules by construction. It raises the search-running line at the strobe for a per-test number of cycles and drives read data only while reads are enabled, and it places on data lane 31 the opposite of the no-match line, so a missing substitution shows up. Host stimulus changes only on falling edges and deliberately includes requests made while busy.

// File: rtl/kms_pkg.sv
// Shared types for the search key match sequencer.
package kms_pkg;
    // Sequencer phases: two write cycles, three read cycles.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WR_STB  = 3'd1,
        ST_WR_WAIT = 3'd2,
        ST_RD_A    = 3'd3,
        ST_RD_B    = 3'd4,
        ST_RD_WAIT = 3'd5
    } kms_state_e;
endpackage

// File: rtl/kms_fsm.sv
// Phase sequencer: runs strobe, stallable write, two read cycles and a
// stallable final read. Assumes abort only asserts while stalled.
module kms_fsm
    import kms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       searching,
    input  logic       abort,
    output kms_state_e state,
    output logic       stall,
    output logic       rd_done
);
    kms_state_e state_nx;

    // A waitable phase freezes while the search line is high.
    assign stall   = ((state == ST_WR_WAIT) || (state == ST_RD_WAIT)) && searching;
    assign rd_done = (state == ST_RD_WAIT) && !searching;

    // Next-phase selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_WR_STB;
            ST_WR_STB:  state_nx = ST_WR_WAIT;
            ST_WR_WAIT: if (abort) state_nx = ST_IDLE;
                        else if (!stall) state_nx = ST_RD_A;
            ST_RD_A:    state_nx = ST_RD_B;
            ST_RD_B:    state_nx = ST_RD_WAIT;
            ST_RD_WAIT: if (abort || !stall) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/kms_timeout.sv
// Counts consecutive stall cycles and flags expiry on the LIMIT-th one.
// Assumes LIMIT >= 2.
module kms_timeout #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT);
    logic [CNT_W-1:0] cnt;

    assign expire = stall && (cnt == CNT_W'(LIMIT - 1));

    // Stall run length; clears whenever the run breaks or expires.
    always_ff @(posedge clk) begin
        if (!rst_n || !stall || expire) cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/kms_result.sv
// Result register: folds the no-match line into the word MSB on a
// completed read, or records a zeroed timeout response on abort.
module kms_result #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_done,
    input  logic              abort,
    input  logic              nomatch,
    input  logic [DATA_W-2:0] rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_word,
    output logic              rsp_hit,
    output logic              rsp_timeout
);
    // Capture the outcome of the lookup that just ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_word    <= '0;
            rsp_hit     <= 1'b0;
            rsp_timeout <= 1'b0;
        end else begin
            rsp_valid <= rd_done || abort;
            if (abort) begin
                rsp_word    <= '0;
                rsp_hit     <= 1'b0;
                rsp_timeout <= 1'b1;
            end else if (rd_done) begin
                rsp_word    <= {nomatch, rdata};
                rsp_hit     <= !nomatch;
                rsp_timeout <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/key_match_seq.sv
// Top of the search key match sequencer: one atomic key write plus result
// read per request. Assumes the device raises dev_searching only after a
// strobe and drives dev_rdata/dev_nomatch while dev_rd_n is low.
module key_match_seq
    import kms_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int TIMEOUT_CYC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_key,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_word,
    output logic              rsp_hit,
    output logic              rsp_timeout,
    output logic [DATA_W-1:0] dev_key,
    output logic              dev_key_drv,
    output logic              dev_start_n,
    output logic              dev_rd_n,
    input  logic              dev_searching,
    input  logic              dev_nomatch,
    input  logic [DATA_W-2:0] dev_rdata
);
    kms_state_e        state;
    logic              start, stall, rd_done, abort;
    logic [DATA_W-1:0] key_q;

    assign busy  = (state != ST_IDLE);
    assign start = req_valid && !busy;

    // Key holding register, loaded only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)     key_q <= '0;
        else if (start) key_q <= req_key;
    end

    // Device pin decode from the current phase.
    assign dev_key     = key_q;
    assign dev_key_drv = (state == ST_WR_STB) || (state == ST_WR_WAIT);
    assign dev_start_n = (state != ST_WR_STB);
    assign dev_rd_n    = !((state == ST_RD_A) || (state == ST_RD_B) || (state == ST_RD_WAIT));

    kms_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .searching (dev_searching),
        .abort     (abort),
        .state     (state),
        .stall     (stall),
        .rd_done   (rd_done)
    );

    kms_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (stall),
        .expire (abort)
    );

    kms_result #(.DATA_W(DATA_W)) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_done     (rd_done),
        .abort       (abort),
        .nomatch     (dev_nomatch),
        .rdata       (dev_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_word    (rsp_word),
        .rsp_hit     (rsp_hit),
        .rsp_timeout (rsp_timeout)
    );
endmodule

// File: rtl/kms_checker.sv
// Port-level protocol checks for key_match_seq, attached by bind.
module kms_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_word,
    input logic              rsp_hit,
    input logic              rsp_timeout,
    input logic [DATA_W-1:0] dev_key,
    input logic              dev_key_drv,
    input logic              dev_start_n,
    input logic              dev_rd_n
);
    // R2: acceptance from idle is followed by the strobe.
    p_accept_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (!dev_start_n && busy));

    // R2: the strobe lasts a single cycle.
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_start_n |=> dev_start_n);

    // R3: the key stays put while it is being driven.
    p_key_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_key_drv && $past(dev_key_drv)) |-> $stable(dev_key));

    // R4: no strobe during a read, no key drive during a read.
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rd_n |-> (dev_start_n && !dev_key_drv));

    // R5: the response is a one-cycle pulse while not busy.
    p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!busy ##1 !rsp_valid));

    // R5: hit flag agrees with the folded MSB on a completed lookup.
    p_hit_sense_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_timeout) |-> (rsp_hit == !rsp_word[DATA_W-1]));

    // R7: a timeout response carries no data and no hit.
    p_timeout_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_timeout) |-> (!rsp_hit && rsp_word == '0));
endmodule

bind key_match_seq kms_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .rsp_valid   (rsp_valid),
    .rsp_word    (rsp_word),
    .rsp_hit     (rsp_hit),
    .rsp_timeout (rsp_timeout),
    .dev_key     (dev_key),
    .dev_key_drv (dev_key_drv),
    .dev_start_n (dev_start_n),
    .dev_rd_n    (dev_rd_n)
);

// File: tb/key_match_seq_tb.sv
// Directed bench for key_match_seq with a behavioural match-port model.
module key_match_seq_tb;
    localparam int TMO = 16;
    localparam logic [31:0] SCRAMBLE = 32'h5A5A_0F0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_key = '0;
    logic        busy, rsp_valid, rsp_hit, rsp_timeout;
    logic [31:0] rsp_word, dev_key;
    logic        dev_key_drv, dev_start_n, dev_rd_n;
    logic        dev_searching = 1'b0;
    logic        dev_nomatch;
    logic [30:0] dev_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Device model configuration and state.
    int          hold_cfg = 0;
    logic        miss_cfg = 1'b0;
    int          rem = 0;
    logic [31:0] lat_key = '0;

    always #2.5 clk = ~clk;

    key_match_seq #(.DATA_W(32), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_key(req_key),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .rsp_hit(rsp_hit), .rsp_timeout(rsp_timeout), .dev_key(dev_key),
        .dev_key_drv(dev_key_drv), .dev_start_n(dev_start_n),
        .dev_rd_n(dev_rd_n), .dev_searching(dev_searching),
        .dev_nomatch(dev_nomatch), .dev_rdata(dev_rdata)
    );

    // Match-port model: latch key on strobe, search line high for hold_cfg cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            rem = 0;
            dev_searching = 1'b0;
        end else if (!dev_start_n) begin
            lat_key = dev_key;
            rem = hold_cfg;
            dev_searching = (hold_cfg > 0);
        end else begin
            if (rem > 0) rem = rem - 1;
            dev_searching = (rem > 0);
        end
    end

    // Read data; lane 31 of the raw data is the opposite of the no-match line.
    logic [31:0] raw_word;
    assign raw_word    = {~miss_cfg, lat_key[30:0] ^ SCRAMBLE[30:0]};
    assign dev_rdata   = dev_rd_n ? '1 : raw_word[30:0];
    assign dev_nomatch = dev_rd_n ? 1'b1 : miss_cfg;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // R1: outputs after reset.
    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0, "R1 busy", 32'(busy), 0);
        chk(rsp_valid == 0, "R1 rsp_valid", 32'(rsp_valid), 0);
        chk(rsp_timeout == 0, "R1 rsp_timeout", 32'(rsp_timeout), 0);
        chk(dev_key_drv == 0, "R1 dev_key_drv", 32'(dev_key_drv), 0);
        chk(dev_start_n && dev_rd_n, "R1 strobes idle",
            32'({dev_start_n, dev_rd_n}), 32'h3);
    endtask

    // One lookup; checks R2-R7 against values computed from the requirements.
    task automatic run_lookup(input logic [31:0] key, input int hold, input logic miss,
                              input bit poke, input bit expect_tmo, input string tag);
        int n = 0, busy_n = 0, stb_n = 0, rd_n = 0;
        bit key_ok = 1, drv_ok = 1, got = 0;
        int exp_busy;
        logic [31:0] exp_word;
        hold_cfg = hold;
        miss_cfg = miss;
        @(negedge clk);
        req_valid = 1'b1;
        req_key   = key;
        @(negedge clk);
        req_valid = 1'b0;
        while (!got && n < 1000) begin
            if (rsp_valid) got = 1;
            else begin
                busy_n += int'(busy);
                if (!dev_start_n) begin
                    stb_n++;
                    if (dev_key !== key || !dev_key_drv) key_ok = 0;
                end
                if (!dev_rd_n) begin
                    rd_n++;
                    if (dev_key_drv) drv_ok = 0;
                end
                if (poke && (n == 2 || n == 3)) begin
                    req_valid = 1'b1;
                    req_key   = ~key;
                end else req_valid = 1'b0;
                @(negedge clk);
                n++;
            end
        end
        chk(got, {tag, " R5 response seen"}, 32'(got), 1);
        chk(stb_n == 1, {tag, " R2 strobe count"}, 32'(stb_n), 1);
        chk(key_ok, {tag, " R2 key on strobe"}, dev_key, key);
        if (expect_tmo) begin
            exp_busy = TMO + 1;
            chk(rsp_timeout == 1, {tag, " R7 timeout flag"}, 32'(rsp_timeout), 1);
            chk(rsp_word == 0 && rsp_hit == 0, {tag, " R7 zero result"},
                rsp_word, 0);
            chk(rd_n == 0, {tag, " R7 no read"}, 32'(rd_n), 0);
        end else begin
            exp_busy = 5 + ((hold > 0) ? hold - 1 : 0);
            exp_word = {miss, key[30:0] ^ SCRAMBLE[30:0]};
            chk(rsp_timeout == 0, {tag, " R5 no timeout"}, 32'(rsp_timeout), 0);
            chk(rsp_word == exp_word, {tag, " R5 word"}, rsp_word, exp_word);
            chk(rsp_hit == !miss, {tag, " R5 hit"}, 32'(rsp_hit), 32'(!miss));
            chk(rd_n == 3, {tag, " R4 read cycles"}, 32'(rd_n), 3);
            chk(drv_ok, {tag, " R4 no drive in read"}, 32'(drv_ok), 1);
        end
        chk(busy_n == exp_busy, {tag, " R3 R6 busy length"}, 32'(busy_n), 32'(exp_busy));
        chk(busy == 0, {tag, " R6 busy low at response"}, 32'(busy), 0);
        @(negedge clk);
        chk(rsp_valid == 0, {tag, " R5 single pulse"}, 32'(rsp_valid), 0);
        repeat (2) @(negedge clk);
        chk(busy == 0 && dev_start_n, {tag, " R6 no extra lookup"},
            32'({busy, dev_start_n}), 32'h1);
    endtask

    task automatic t_hit_no_wait();
        run_lookup(32'h1234_5678, 0, 1'b0, 0, 0, "hit_nowait");
    endtask

    task automatic t_miss_with_wait();
        run_lookup(32'h8000_00A5, 6, 1'b1, 0, 0, "miss_wait");
    endtask

    task automatic t_ignore_while_busy();
        run_lookup(32'hCAFE_0001, 4, 1'b0, 1, 0, "ignore_busy");
    endtask

    task automatic t_wait_below_limit();
        run_lookup(32'hFFFF_FFFF, TMO, 1'b0, 0, 0, "wait_near_limit");
    endtask

    task automatic t_timeout();
        run_lookup(32'h0BAD_F00D, 1000, 1'b0, 0, 1, "timeout");
    endtask

    initial begin
        t_reset_state();
        t_hit_no_wait();
        t_miss_with_wait();
        t_ignore_while_busy();
        t_wait_below_limit();
        t_timeout();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule